// File: doc/BRIEF.md
# Burst-Continuity Checking Bus Slave

This block is an AHB-Lite slave endpoint that verifies the addresses within an incrementing burst. Each time it accepts an address phase, it works out which address the next sequential beat has to carry. A sequential beat whose address is different from that prediction is rejected with the standard two-cycle ERROR response. Every other transfer gets an OKAY response with no wait states. The block has no storage behind it. Its only outputs are the data-phase handshake (ready-out and response) and a running count of error events.

An address phase is taken only when the bus-wide ready signal is high and the slave is selected. A master may keep sending the rest of a burst after an error. The slave accepts a beat offered during the second error cycle and judges it like any other beat. After a rejected beat, the prediction moves on as though that beat had completed. The transfer-type encoding is IDLE=0, BUSY=1, NONSEQ=2, SEQ=3. A beat advances the address by 2^size bytes, where size is the transfer-size code.

The block is a bus endpoint, so it has no valid/ready stream interface. The ready-in signal works as the only back-pressure: while it is low, nothing presented on the address lines is taken.

Top module: `ahb_burst_chk`

## Requirements
- R1: After reset, ready-out is 1, the response is OKAY (0), the error count is 0 and the predicted address is 0.
- R2: A transfer that is selected and accepted, and is IDLE, BUSY, NONSEQ or a matching SEQ, is followed by one data-phase cycle with ready-out 1 and response OKAY.
- R3: An accepted SEQ beat whose address differs from the predicted address is followed by a first error cycle with ready-out 0 and response ERROR (1).
- R4: The first error cycle is always followed by a second error cycle with ready-out 1 and response ERROR. If no new beat is accepted in that second cycle, the next cycle returns OKAY.
- R5: An address phase presented while ready-in is low is not accepted. It changes neither the response sequence nor the prediction nor the count.
- R6: An accepted NONSEQ sets the prediction to its address plus 2^size. An accepted SEQ, matching or not, sets the prediction to the old prediction plus 2^size.
- R7: A beat accepted during the second error cycle is judged like any other beat: it gets OKAY if it matches and a new error if it does not.
- R8: The error count rises by exactly one per rejected beat and shows the new value during the first error cycle. It wraps modulo 2^CNT_W.
- R9: Transfers presented while the slave is not selected have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | Slave select |
| hready | input | 1 | Bus-wide ready-in; an address phase is taken only when high |
| htrans | input | 2 | Transfer type (0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ) |
| haddr | input | ADDR_W | Byte address |
| hsize | input | 3 | Transfer size code; a beat spans 2^hsize bytes |
| hreadyout | output | 1 | Data-phase ready driven by this slave |
| hresp | output | 1 | Data-phase response, 0 OKAY, 1 ERROR |
| err_count | output | CNT_W | Count of ERROR responses issued |

## Verification
The hardest case to reach is a beat accepted in the second error cycle, particularly when that beat fails too, so that two error pairs run back to back. A directed sequence covers it: it repeats an address that has already been served and then keeps the burst going during the error pair. Random traffic adds to this. That traffic mostly sends the predicted address but often repeats the previous one, and it mixes in stalls on ready-in. Together these cover errors that arrive while the slave is stalled, or in a chain, and enough of them to make the counter wrap.

// File: rtl/ahb_burst_chk_pkg.sv
package ahb_burst_chk_pkg;

  typedef enum logic [1:0] {
    TR_IDLE = 2'd0,
    TR_BUSY = 2'd1,
    TR_NSEQ = 2'd2,
    TR_SEQ  = 2'd3
  } trans_e;

  typedef enum logic [1:0] {
    RS_OK   = 2'd0,
    RS_ERR1 = 2'd1,
    RS_ERR2 = 2'd2
  } rstate_e;

  function automatic logic is_active(input logic [1:0] tr);
    return (tr == TR_NSEQ) || (tr == TR_SEQ);
  endfunction

endpackage

// File: rtl/burst_tracker.sv
module burst_tracker #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hready,
  input  logic              take,
  input  logic              is_seq,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  output logic              mismatch
);

  logic [ADDR_W-1:0] exp_q;
  logic [ADDR_W-1:0] step;

  assign step     = ADDR_W'(1) << size;
  assign mismatch = is_seq && (addr != exp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= '0;
    end else if (take) begin
      // a failed SEQ still advances the prediction as if it had completed
      exp_q <= (is_seq ? exp_q : addr) + step;
    end
  end

  // R5: with ready-in low nothing is taken, so the prediction holds
  a_r5_hold_exp: assert property (@(posedge clk) disable iff (!rst_n)
    !hready |=> $stable(exp_q));

  // R6: a SEQ beat always moves the prediction by its own size
  a_r6_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_seq) |=> (exp_q == $past(exp_q) + $past(step)));

endmodule

// File: rtl/resp_fsm.sv
module resp_fsm
  import ahb_burst_chk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic bad,
  output logic hreadyout,
  output logic hresp
);

  rstate_e st_q, st_d;

  always_comb begin
    if (take) begin
      st_d = bad ? RS_ERR1 : RS_OK;
    end else if (st_q == RS_ERR1) begin
      st_d = RS_ERR2;
    end else begin
      st_d = RS_OK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RS_OK;
    else        st_q <= st_d;
  end

  assign hreadyout = (st_q != RS_ERR1);
  assign hresp     = (st_q != RS_OK);

  // R4: the low-ready error cycle is always followed by the high-ready one
  a_r4_err_second: assert property (@(posedge clk) disable iff (!rst_n)
    !hreadyout |=> (hreadyout && hresp));

  // R4: an error pair never starts without a rejected beat
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!(take && bad)) |=> hreadyout);

endmodule

// File: rtl/err_counter.sv
module err_counter #(
  parameter int CNT_W = 8,
  parameter bit SAT   = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  generate
    if (SAT) begin : g_sat
      assign cnt_inc = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
    end else begin : g_wrap
      assign cnt_inc = cnt_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (bump) cnt_q <= cnt_inc;
  end

  assign count = cnt_q;

  // R8: the count moves only on an error event
  a_r8_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !bump |=> $stable(count));

endmodule

// File: rtl/ahb_burst_chk.sv
module ahb_burst_chk
  import ahb_burst_chk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsel,
  input  logic              hready,
  input  logic [1:0]        htrans,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [2:0]        hsize,
  output logic              hreadyout,
  output logic              hresp,
  output logic [CNT_W-1:0]  err_count
);

  logic take;
  logic is_seq;
  logic mismatch;
  logic reject;

  assign take   = hsel && hready && is_active(htrans);
  assign is_seq = (htrans == TR_SEQ);
  assign reject = take && mismatch;

  burst_tracker #(.ADDR_W(ADDR_W)) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hready   (hready),
    .take     (take),
    .is_seq   (is_seq),
    .addr     (haddr),
    .size     (hsize),
    .mismatch (mismatch)
  );

  resp_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .bad       (mismatch),
    .hreadyout (hreadyout),
    .hresp     (hresp)
  );

  err_counter #(.CNT_W(CNT_W), .SAT(1'b0)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (reject),
    .count (err_count)
  );

  // R3: a rejected beat opens the error pair with ready low
  a_r3_err_first: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (!hreadyout && hresp));

  // R2: an accepted good beat gets a zero-wait OKAY
  a_r2_okay: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !mismatch) |=> (hreadyout && !hresp));

  // R8: one increment per rejected beat, seen in the first error cycle
  a_r8_bump: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (err_count == CNT_W'($past(err_count) + 1'b1)));

endmodule

// File: tb/sim_ahb_burst_chk.sv
`timescale 1ns/1ps
module sim_ahb_burst_chk;

  localparam int AW = 32;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hsel = 1'b0;
  logic          stall = 1'b0;
  logic [1:0]    htrans = 2'd0;
  logic [AW-1:0] haddr = '0;
  logic [2:0]    hsize = 3'd2;
  logic          hready;
  logic          hreadyout;
  logic          hresp;
  logic [CW-1:0] err_count;

  assign hready = hreadyout & ~stall;

  always #10 clk = ~clk;

  ahb_burst_chk #(.ADDR_W(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .hready(hready),
    .htrans(htrans), .haddr(haddr), .hsize(hsize),
    .hreadyout(hreadyout), .hresp(hresp), .err_count(err_count)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference model: 0 OK, 1 first error, 2 second error
  int            m_st  = 0;
  logic [AW-1:0] m_exp = '0;
  logic [CW-1:0] m_cnt = '0;
  string         m_tag = "R1";

  function automatic bit exp_ready(input int st);
    return st != 1;
  endfunction

  function automatic bit exp_resp(input int st);
    return st != 0;
  endfunction

  function automatic logic [AW-1:0] step_of(input logic [2:0] sz);
    return AW'(1) << sz;
  endfunction

  task automatic check_outputs();
    total++;
    if (hreadyout !== exp_ready(m_st) || hresp !== exp_resp(m_st)) begin
      bad++;
      $display("FAIL %s: ready/resp actual=%0b/%0b expected=%0b/%0b",
               m_tag, hreadyout, hresp, exp_ready(m_st), exp_resp(m_st));
    end
    total++;
    if (err_count !== m_cnt) begin
      bad++;
      $display("FAIL R8: err_count actual=%0d expected=%0d", err_count, m_cnt);
    end
  endtask

  task automatic cyc(input bit sel, input logic [1:0] tr,
                     input logic [AW-1:0] a, input logic [2:0] sz, input bit stl);
    bit hr, acc, mis;
    @(negedge clk);
    check_outputs();
    hsel = sel; htrans = tr; haddr = a; hsize = sz; stall = stl;
    hr  = exp_ready(m_st) && !stl;
    acc = sel && hr && tr[1];
    mis = acc && (tr == 2'd3) && (a != m_exp);
    if (m_st == 1)              m_tag = "R4";
    else if (!sel)              m_tag = "R9";
    else if (!hr && tr[1])      m_tag = "R5";
    else if (acc && m_st == 2)  m_tag = "R7";
    else if (mis)               m_tag = "R3";
    else if (acc && tr == 2'd3) m_tag = "R6";
    else if (m_st == 2)         m_tag = "R4";
    else                        m_tag = "R2";
    if (acc) begin
      m_exp = (tr == 2'd3 ? m_exp : a) + step_of(sz);
      if (mis) begin
        m_cnt = m_cnt + 1'b1;
        m_st  = 1;
      end else begin
        m_st = 0;
      end
    end else begin
      m_st = (m_st == 1) ? 2 : 0;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(1234);
    repeat (2) @(negedge clk);
    m_tag = "R1";
    check_outputs();
    rst_n = 1'b1;

    // R2/R6: clean INCR4 word burst
    cyc(1, 2'd2, 32'h20, 3'd2, 0);
    cyc(1, 2'd3, 32'h24, 3'd2, 0);
    cyc(1, 2'd3, 32'h28, 3'd2, 0);
    cyc(1, 2'd3, 32'h2C, 3'd2, 0);
    cyc(1, 2'd0, 32'h0,  3'd2, 0);
    // R3: repeat an already-served address, then R7 continue in second error cycle
    cyc(1, 2'd2, 32'h40, 3'd2, 0);
    cyc(1, 2'd3, 32'h44, 3'd2, 0);
    cyc(1, 2'd3, 32'h44, 3'd2, 0);   // mismatch: prediction was 0x48
    cyc(1, 2'd3, 32'h4C, 3'd2, 0);   // first error cycle, held (not taken)
    cyc(1, 2'd3, 32'h4C, 3'd2, 0);   // second error cycle: taken, matches
    cyc(1, 2'd3, 32'h40, 3'd2, 0);   // mismatch again
    cyc(1, 2'd3, 32'h40, 3'd2, 0);
    cyc(1, 2'd3, 32'h12, 3'd2, 0);   // R7: second error cycle, mismatch -> new pair
    cyc(1, 2'd0, 32'h0,  3'd2, 0);
    cyc(1, 2'd0, 32'h0,  3'd2, 0);
    cyc(1, 2'd0, 32'h0,  3'd2, 0);
    // R5: held address while ready-in low
    cyc(1, 2'd2, 32'h100, 3'd1, 0);
    cyc(1, 2'd3, 32'h500, 3'd1, 1);  // stalled, ignored
    cyc(1, 2'd3, 32'h102, 3'd1, 0);  // halfword step matches
    // R9: unselected traffic
    cyc(0, 2'd2, 32'h900, 3'd2, 0);
    cyc(0, 2'd3, 32'h777, 3'd2, 0);
    cyc(1, 2'd3, 32'h104, 3'd1, 0);
    cyc(1, 2'd1, 32'h0,   3'd1, 0);  // BUSY
    cyc(1, 2'd0, 32'h0,   3'd1, 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic [1:0]    tr;
      logic [2:0]    sz;
      logic [AW-1:0] a;
      r  = $urandom % 100;
      tr = (r < 10) ? 2'd0 : (r < 15) ? 2'd1 : (r < 35) ? 2'd2 : 2'd3;
      sz = 3'($urandom % 3);
      r  = $urandom % 100;
      if (r < 60)      a = m_exp;
      else if (r < 85) a = m_exp - step_of(sz);
      else             a = {$urandom} & 32'hFFFC;
      cyc(($urandom % 10) != 0, tr, a, sz, ($urandom % 100) < 15);
    end
    cyc(1, 2'd0, 32'h0, 3'd2, 0);
    cyc(1, 2'd0, 32'h0, 3'd2, 0);
    @(negedge clk);
    check_outputs();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule